// File: doc/BRIEF.md
# Paged DMA Bus Address Generator

This block produces the full bus address for a single DMA channel. The address is assembled from three registers. The first is a 16-bit current-address counter. The second is an 8-bit page register above it. The third is an 8-bit high-page register that supplies the top byte. After every transfer strobe the counter advances by one and a separate 16-bit transfer counter goes down by one. When that transfer counter underflows, a terminal-count pulse is raised.

A static parameter builds the channel in one of two modes:

- **Byte mode:** the counter addresses bytes, and all eight page bits take part in the address.
- **Word mode:** the counter addresses 16-bit words. It is shifted left by one, bus bit 0 is forced to zero and page bit 0 plays no part. A single programmed run can therefore cover 128 KB instead of 64 KB.

A two-state machine controls whether the counter may carry into the page bits:

- **ST_LOCKED** (the reset state): the counter wraps inside its page.
- **ST_SPAN**: a counter overflow carries into the page and then into the high page.

Transitions:

- A write to the high-page register moves the machine from ST_LOCKED to ST_SPAN. This is the arm transition.
- A load of the address counter or a write to the page register returns it to ST_LOCKED. This is the disarm transition.
- Disarm wins over arm when both happen in the same cycle.
- In every other cycle the machine holds its state.

For these reasons software writes the high page as the last step of address setup.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset, `bus_addr` is zero, `term_count` is low, and `word_xfer` equals the WORD_CH parameter (0 for byte mode, 1 for word mode).
- R2: In byte mode, `bus_addr` = {high page[7:0], page[7:0], counter[15:0]}.
- R3: In word mode, `bus_addr` = {high page[7:0], page[7:1], counter[15:0], 1'b0}. Page bit 0 has no effect on `bus_addr`.
- R4: Each `xfer_strobe` increments the address counter by one and decrements the transfer counter by one. Both new values hold from the cycle after the strobe edge.
- R5: `term_count` is high for exactly the one cycle after the strobe that takes the transfer counter from 0x0000 to 0xFFFF, and is low otherwise.
- R6: In ST_LOCKED, a strobe with the counter at 0xFFFF wraps the counter to 0x0000 and leaves the page and high page unchanged.
- R7: In ST_SPAN, a counter overflow adds one to the page. In byte mode the unit is page bit 0, and a carry out of bit 7 goes into the high page. In word mode the unit is page bit 1, bit 0 is kept, and a carry out of bit 7 goes into the high page.
- R8: A `hipage_write` arms the machine (ST_SPAN). An `addr_load` or `page_write` disarms it (ST_LOCKED), and disarm wins if both occur together.
- R9: A load or write to a register in the same cycle as a strobe takes precedence over the strobe's update of that register. A count load together with a strobe at count 0 raises no `term_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load the address counter from `addr_data` |
| addr_data | input | 16 | Address counter load value |
| count_load | input | 1 | Load the transfer counter from `count_data` |
| count_data | input | 16 | Transfer counter load value (transfers minus one) |
| page_write | input | 1 | Write the page register |
| page_data | input | 8 | Page register value |
| hipage_write | input | 1 | Write the high-page register; arms page carry |
| hipage_data | input | 8 | High-page register value |
| xfer_strobe | input | 1 | One transfer completed |
| bus_addr | output | 32 | Assembled bus address |
| word_xfer | output | 1 | High when the channel moves 16-bit words |
| term_count | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench builds two copies of the block from the same stimulus: one with WORD_CH=0 and one with WORD_CH=1, both at the default widths. With both present, every address-layout and carry scenario is compared in byte and word form at once. This makes it easy to see that page bit 0 is dropped and that the word carry lands at page bit 1. The 16-bit default counter keeps counter wrap and carry reachable in a single strobe after loading 0xFFFF.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_SPAN   = 1'b1
    } span_state_t;
endpackage

// File: rtl/dpa_addr_ctr.sv
module dpa_addr_ctr #(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    input  logic             step,
    output logic [CTR_W-1:0] ctr,
    output logic             wrap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctr <= '0;
        else if (ld)
            ctr <= ld_val;
        else if (step)
            ctr <= ctr + 1'b1;
    end

    // overflow of this strobe, suppressed when a load takes precedence
    always_comb wrap = step && !ld && (ctr == {CTR_W{1'b1}});

    // R4: a strobe without a load advances the counter by exactly one
    a_r4_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> (ctr == $past(ctr) + 1'b1));
    // R9: a load wins over a simultaneous strobe
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (ctr == $past(ld_val)));
endmodule

// File: rtl/dpa_xfer_cnt.sv
module dpa_xfer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             step,
    output logic             tc
);
    logic [CNT_W-1:0] cnt;
    logic             under;

    always_comb under = step && !ld && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else begin
            tc <= under;
            if (ld)
                cnt <= ld_val;
            else if (step)
                cnt <= cnt - 1'b1;
        end
    end

    // R5: the pulse only follows an underflow into all ones
    a_r5_tc_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (cnt == {CNT_W{1'b1}}));
    a_r5_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
endmodule

// File: rtl/dpa_page_unit.sv
module dpa_page_unit #(
    parameter int PAGE_W   = 8,
    parameter int HIPAGE_W = 8,
    parameter bit WORD_CH  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_wr,
    input  logic [PAGE_W-1:0]   page_val,
    input  logic                hp_wr,
    input  logic [HIPAGE_W-1:0] hp_val,
    input  logic                carry,
    output logic [PAGE_W-1:0]   page,
    output logic [HIPAGE_W-1:0] hp
);
    localparam int UP_W = HIPAGE_W + PAGE_W;

    logic [PAGE_W-1:0]   page_inc;
    logic [HIPAGE_W-1:0] hp_inc;

    generate
        if (WORD_CH) begin : g_word
            logic [UP_W-2:0] upper;
            always_comb begin
                upper    = {hp, page[PAGE_W-1:1]} + 1'b1;
                page_inc = {upper[PAGE_W-2:0], page[0]};
                hp_inc   = upper[UP_W-2:PAGE_W-1];
            end
        end else begin : g_byte
            logic [UP_W-1:0] upper;
            always_comb begin
                upper    = {hp, page} + 1'b1;
                page_inc = upper[PAGE_W-1:0];
                hp_inc   = upper[UP_W-1:PAGE_W];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            hp   <= '0;
        end else begin
            if (page_wr)
                page <= page_val;
            else if (carry)
                page <= page_inc;
            if (hp_wr)
                hp <= hp_val;
            else if (carry)
                hp <= hp_inc;
        end
    end

    // R6: without a carry or a write the page bits never move
    a_r6_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry && !page_wr && !hp_wr) |=> ($stable(page) && $stable(hp)));
    // R9: a page write wins over a carry in the same cycle
    a_r9_page_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> (page == $past(page_val)));
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_pg_pkg::*;
#(
    parameter int CTR_W    = 16,
    parameter int PAGE_W   = 8,
    parameter int HIPAGE_W = 8,
    parameter bit WORD_CH  = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               addr_load,
    input  logic [CTR_W-1:0]                   addr_data,
    input  logic                               count_load,
    input  logic [CTR_W-1:0]                   count_data,
    input  logic                               page_write,
    input  logic [PAGE_W-1:0]                  page_data,
    input  logic                               hipage_write,
    input  logic [HIPAGE_W-1:0]                hipage_data,
    input  logic                               xfer_strobe,
    output logic [HIPAGE_W+PAGE_W+CTR_W-1:0]   bus_addr,
    output logic                               word_xfer,
    output logic                               term_count
);
    localparam int BUS_W = HIPAGE_W + PAGE_W + CTR_W;

    span_state_t         state_q, state_d;
    logic [CTR_W-1:0]    ctr;
    logic                ctr_wrap;
    logic                page_carry;
    logic [PAGE_W-1:0]   page;
    logic [HIPAGE_W-1:0] hp;

    dpa_addr_ctr #(.CTR_W(CTR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld(addr_load), .ld_val(addr_data),
        .step(xfer_strobe), .ctr(ctr), .wrap(ctr_wrap)
    );

    dpa_xfer_cnt #(.CNT_W(CTR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld(count_load), .ld_val(count_data),
        .step(xfer_strobe), .tc(term_count)
    );

    dpa_page_unit #(.PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W), .WORD_CH(WORD_CH)) u_page (
        .clk(clk), .rst_n(rst_n), .page_wr(page_write), .page_val(page_data),
        .hp_wr(hipage_write), .hp_val(hipage_data), .carry(page_carry),
        .page(page), .hp(hp)
    );

    // next-state logic: disarm has priority over arm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (hipage_write && !addr_load && !page_write) state_d = ST_SPAN;
            ST_SPAN:   if (addr_load || page_write)                   state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOCKED;
        else
            state_q <= state_d;
    end

    // output process: carry permission and address layout
    always_comb begin
        page_carry = ctr_wrap && (state_q == ST_SPAN);
        word_xfer  = WORD_CH;
    end

    generate
        if (WORD_CH) begin : g_word_bus
            always_comb bus_addr = {hp, page[PAGE_W-1:1], ctr, 1'b0};
        end else begin : g_byte_bus
            always_comb bus_addr = {hp, page, ctr};
        end
    endgenerate

    // R8: address or page writes always leave the machine locked
    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load || page_write) |=> (state_q == ST_LOCKED));
    // R8: a lone high-page write arms the carry
    a_r8_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (hipage_write && !addr_load && !page_write) |=> (state_q == ST_SPAN));
    // R6: a wrap while locked leaves the top bits of the address alone
    a_r6_locked_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_wrap && state_q == ST_LOCKED && !page_write && !hipage_write)
        |=> $stable(bus_addr[BUS_W-1:CTR_W+1]));
endmodule

// File: tb/test_dma_page_addr_gen.sv
module test_dma_page_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 0, count_load = 0, page_write = 0, hipage_write = 0, xfer_strobe = 0;
    logic [15:0] addr_data = 0, count_data = 0;
    logic [7:0]  page_data = 0, hipage_data = 0;
    logic [31:0] bus_b, bus_w;
    logic        word_b, word_w, tc_b, tc_w;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    dma_page_addr_gen #(.WORD_CH(1'b0)) i_dma_page_addr_gen (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_data(addr_data),
        .count_load(count_load), .count_data(count_data), .page_write(page_write),
        .page_data(page_data), .hipage_write(hipage_write), .hipage_data(hipage_data),
        .xfer_strobe(xfer_strobe), .bus_addr(bus_b), .word_xfer(word_b), .term_count(tc_b)
    );

    dma_page_addr_gen #(.WORD_CH(1'b1)) i_dma_page_addr_gen_w (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_data(addr_data),
        .count_load(count_load), .count_data(count_data), .page_write(page_write),
        .page_data(page_data), .hipage_write(hipage_write), .hipage_data(hipage_data),
        .xfer_strobe(xfer_strobe), .bus_addr(bus_w), .word_xfer(word_w), .term_count(tc_w)
    );

    function automatic logic [31:0] exp_bus(input bit word, input logic [7:0] hp,
                                            input logic [7:0] pg, input logic [15:0] c);
        if (word) return {hp, pg[7:1], c, 1'b0};
        return {hp, pg, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // each register operation occupies one cycle; driven and cleared at negedge
    task automatic wr_addr(input logic [15:0] v);
        @(negedge clk); addr_load = 1; addr_data = v;
        @(negedge clk); addr_load = 0;
    endtask
    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); count_load = 1; count_data = v;
        @(negedge clk); count_load = 0;
    endtask
    task automatic wr_page(input logic [7:0] v);
        @(negedge clk); page_write = 1; page_data = v;
        @(negedge clk); page_write = 0;
    endtask
    task automatic wr_hp(input logic [7:0] v);
        @(negedge clk); hipage_write = 1; hipage_data = v;
        @(negedge clk); hipage_write = 0;
    endtask
    task automatic strobe;
        @(negedge clk); xfer_strobe = 1;
        @(negedge clk); xfer_strobe = 0;
    endtask

    task automatic t_reset;
        chk("R1 byte bus", bus_b, 32'h0);
        chk("R1 word bus", bus_w, 32'h0);
        chk("R1 tc", {30'b0, tc_b, tc_w}, 32'h0);
        chk("R1 word flags", {30'b0, word_b, word_w}, 32'h1);
    endtask

    task automatic t_layout;
        wr_addr(16'h1234); wr_page(8'h57); wr_hp(8'h9A);
        chk("R2 byte layout", bus_b, exp_bus(0, 8'h9A, 8'h57, 16'h1234));
        chk("R3 word layout", bus_w, exp_bus(1, 8'h9A, 8'h57, 16'h1234));
        wr_page(8'h56);
        chk("R3 page bit0 ignored", bus_w, 32'h9A562468);
        chk("R2 byte page bit0 used", bus_b, 32'h9A561234);
    endtask

    task automatic t_step_tc;
        wr_addr(16'h0010); wr_cnt(16'h0002);
        strobe();
        chk("R4 step one", bus_b[15:0], 32'h0011);
        chk("R5 no tc at count 1", {31'b0, tc_b}, 32'h0);
        strobe();
        chk("R4 word step", bus_w[16:0], 32'h0024);
        chk("R5 no tc at count 0", {31'b0, tc_w}, 32'h0);
        strobe();
        chk("R5 tc byte", {31'b0, tc_b}, 32'h1);
        chk("R5 tc word", {31'b0, tc_w}, 32'h1);
        @(negedge clk);
        chk("R5 tc single cycle", {31'b0, tc_b}, 32'h0);
        strobe();
        chk("R5 no tc after underflow", {31'b0, tc_b}, 32'h0);
    endtask

    task automatic t_wrap_locked;
        wr_hp(8'h11); wr_page(8'h40); wr_addr(16'hFFFF);
        strobe();
        chk("R6 byte wrap", bus_b, exp_bus(0, 8'h11, 8'h40, 16'h0000));
        chk("R6 word wrap", bus_w, exp_bus(1, 8'h11, 8'h40, 16'h0000));
    endtask

    task automatic t_carry;
        wr_addr(16'hFFFF); wr_page(8'hFF); wr_hp(8'h12);
        strobe();
        chk("R7 byte carry into hp", bus_b, 32'h13000000);
        chk("R7 word carry into hp", bus_w, 32'h13000000);
        wr_addr(16'hFFFF); wr_page(8'h40); wr_hp(8'h13);
        strobe();
        chk("R7 byte page+1", bus_b, exp_bus(0, 8'h13, 8'h41, 16'h0000));
        chk("R7 word page+2", bus_w, exp_bus(1, 8'h13, 8'h42, 16'h0000));
    endtask

    task automatic t_disarm;
        wr_addr(16'hFFFF); wr_hp(8'h05); wr_page(8'h40);
        strobe();
        chk("R8 page write disarms", bus_b, exp_bus(0, 8'h05, 8'h40, 16'h0000));
        wr_page(8'h40); wr_hp(8'h05); wr_addr(16'hFFFF);
        strobe();
        chk("R8 addr load disarms", bus_w, exp_bus(1, 8'h05, 8'h40, 16'h0000));
        @(negedge clk);
        hipage_write = 1; hipage_data = 8'h06; addr_load = 1; addr_data = 16'hFFFF;
        @(negedge clk); hipage_write = 0; addr_load = 0;
        strobe();
        chk("R8 disarm wins over arm", bus_b, exp_bus(0, 8'h06, 8'h40, 16'h0000));
    endtask

    task automatic t_precedence;
        @(negedge clk); addr_load = 1; addr_data = 16'h0100; xfer_strobe = 1;
        @(negedge clk); addr_load = 0; xfer_strobe = 0;
        chk("R9 load beats strobe", bus_b[15:0], 32'h0100);
        wr_cnt(16'h0000);
        @(negedge clk); count_load = 1; count_data = 16'h0000; xfer_strobe = 1;
        @(negedge clk); count_load = 0; xfer_strobe = 0;
        chk("R9 no tc with count load", {31'b0, tc_b}, 32'h0);
        strobe();
        chk("R9 tc after reload", {31'b0, tc_b}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_step_tc();
        t_wrap_locked();
        t_carry();
        t_disarm();
        t_precedence();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule